// File: doc/BRIEF.md
# Multiplexed LCD Row-Scan Timing Generator

This block derives the row-scan timing of a multiplexed dot-matrix character display from the oscillator clock. Two configuration inputs select the duty mode:

- 8 rows for a single line with the short font.
- 11 rows for a single line with the tall font.
- 16 rows for two lines of the short font.

The block walks a row counter through the active rows and drives one common-row select line at a time. It also produces a strobe in the last clock of every row, so that pattern fetch logic can latch the data for the next row. The current row index is output for the same fetch logic.

A polarity alternation signal reverses the panel drive so that no net DC reaches the liquid crystal. A static strap selects how often it flips:

- Style A flips it at every row boundary.
- Style B flips it once per frame.

A new duty mode set on the inputs is adopted only at a frame boundary, and the scan then starts again from row 0. Bias generation and the analog drivers sit outside the block; every output is a logical level.

Top module: `lcd_scan_timer`

## Requirements
- R1: With `two_line_i`=1 a frame has 16 rows, whatever `tall_font_i` is. Otherwise `tall_font_i`=1 gives 11 rows and `tall_font_i`=0 gives 8 rows.
- R2: A row lasts ROW_LONG clocks (default 400) in the 8-row and 11-row modes, and ROW_SHORT clocks (default 200) in the 16-row mode.
- R3: `row_idx_o` counts 0,1,… up to rows-1 within a frame, then returns to 0.
- R4: `com_sel_o` is one-hot, and bit k is high exactly while `row_idx_o`==k. Commons at or above the active row count are never selected.
- R5: `row_strobe_o` is high for exactly one clock per row, the last clock before the row boundary.
- R6: With `wave_b_i`=0, `ac_o` inverts at every row boundary.
- R7: With `wave_b_i`=1, `ac_o` inverts only at frame boundaries, so it is constant within a frame.
- R8: `two_line_i` and `tall_font_i` are sampled only at a frame boundary. A change made during a frame takes effect from row 0 of the following frame.
- R9: While `rst_ni` is low, the block is in row 0 with only `com_sel_o[0]` set, `ac_o`=0 and `row_strobe_o`=0. The first frame after reset uses the 8-row mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| two_line_i | input | 1 | Two-line display select |
| tall_font_i | input | 1 | Tall (5x10) font select for single-line use |
| wave_b_i | input | 1 | Static strap: 0 = flip polarity per row, 1 = flip per frame |
| com_sel_o | output | NUM_COMS | One-hot common-row select |
| row_idx_o | output | $clog2(NUM_COMS) | Current row index for pattern fetch |
| row_strobe_o | output | 1 | High in the last clock of each row |
| ac_o | output | 1 | Drive polarity alternation signal |

## Verification
The strobe and the row index, common select and polarity that belong with it are all valid during the last clock of a row. The bench therefore samples them on the falling edge while the strobe is high and compares them with the next item in the expected queue. The row length is the number of falling edges between consecutive strobes.

A polarity flip is registered on the boundary edge, so it first appears on the next row's strobe sample. A mode change set in row 0 of a frame appears only in the row count and row length of the frame after it. The expected model places each change accordingly.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    DUTY_8  = 2'd0,
    DUTY_11 = 2'd1,
    DUTY_16 = 2'd2
  } duty_e;

  function automatic duty_e duty_from_cfg(input logic two_line, input logic tall_font);
    if (two_line)       return DUTY_16;
    else if (tall_font) return DUTY_11;
    else                return DUTY_8;
  endfunction
endpackage

// File: rtl/lcd_duty_sel.sv
module lcd_duty_sel
  import lcd_scan_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  two_line_i,
  input  logic  tall_font_i,
  input  logic  frame_end_i,
  output duty_e duty_o
);
  duty_e duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          duty_q <= DUTY_8;
    else if (frame_end_i) duty_q <= duty_from_cfg(two_line_i, tall_font_i);
  end

  assign duty_o = duty_q;

  // mode only moves on a frame boundary
  assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(duty_q));
endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMS  = 16,
  parameter int TALL_ROWS = 11,
  parameter int ROW_LONG  = 400,
  parameter int ROW_SHORT = 200,
  localparam int ROW_W    = $clog2(NUM_COMS),
  localparam int CNT_W    = $clog2(ROW_LONG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  duty_e            duty_i,
  output logic [ROW_W-1:0] row_o,
  output logic             row_last_o,
  output logic             frame_last_o
);
  logic [CNT_W-1:0] cnt_q, last_cnt;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W:0]   rows;

  always_comb begin
    unique case (duty_i)
      DUTY_16: begin rows = (ROW_W+1)'(NUM_COMS);     last_cnt = CNT_W'(ROW_SHORT - 1); end
      DUTY_11: begin rows = (ROW_W+1)'(TALL_ROWS);    last_cnt = CNT_W'(ROW_LONG - 1);  end
      default: begin rows = (ROW_W+1)'(NUM_COMS / 2); last_cnt = CNT_W'(ROW_LONG - 1);  end
    endcase
  end

  assign row_last_o   = (cnt_q == last_cnt);
  assign frame_last_o = row_last_o && ({1'b0, row_q} == rows - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      row_q <= '0;
    end else if (row_last_o) begin
      cnt_q <= '0;
      row_q <= frame_last_o ? '0 : row_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign row_o = row_q;

  assert_row_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, row_q} < rows);
  assert_row_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_last_o |=> $stable(row_q));
  assert_strobe_restarts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_last_o |=> (cnt_q == '0));
  assert_frame_restarts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_o |=> (row_q == '0));
endmodule

// File: rtl/lcd_ac_gen.sv
module lcd_ac_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wave_b_i,
  input  logic row_end_i,
  input  logic frame_end_i,
  output logic ac_o
);
  logic ac_q, flip;

  assign flip = wave_b_i ? frame_end_i : row_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ac_q <= 1'b0;
    else if (flip) ac_q <= ~ac_q;
  end

  assign ac_o = ac_q;

  assert_flip_per_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_end_i && !wave_b_i) |=> (ac_q != $past(ac_q)));
  assert_hold_in_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_end_i |=> $stable(ac_q));
  assert_hold_in_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_b_i && !frame_end_i) |=> $stable(ac_q));
endmodule

// File: rtl/lcd_com_decode.sv
module lcd_com_decode #(
  parameter int NUM_COMS = 16,
  localparam int ROW_W   = $clog2(NUM_COMS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ROW_W-1:0]    row_i,
  output logic [NUM_COMS-1:0] com_o
);
  for (genvar k = 0; k < NUM_COMS; k++) begin : g_com
    assign com_o[k] = (row_i == ROW_W'(k));
  end

  assert_one_common_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(com_o) == 1);
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMS  = 16,
  parameter int TALL_ROWS = 11,
  parameter int ROW_LONG  = 400,
  parameter int ROW_SHORT = 200
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          two_line_i,
  input  logic                          tall_font_i,
  input  logic                          wave_b_i,
  output logic [NUM_COMS-1:0]           com_sel_o,
  output logic [$clog2(NUM_COMS)-1:0]   row_idx_o,
  output logic                          row_strobe_o,
  output logic                          ac_o
);
  duty_e duty;
  logic  row_end, frame_end;
  logic [$clog2(NUM_COMS)-1:0] row;

  lcd_duty_sel u_duty (
    .clk_i, .rst_ni, .two_line_i, .tall_font_i,
    .frame_end_i(frame_end), .duty_o(duty)
  );

  lcd_row_timer #(
    .NUM_COMS(NUM_COMS), .TALL_ROWS(TALL_ROWS),
    .ROW_LONG(ROW_LONG), .ROW_SHORT(ROW_SHORT)
  ) u_timer (
    .clk_i, .rst_ni, .duty_i(duty),
    .row_o(row), .row_last_o(row_end), .frame_last_o(frame_end)
  );

  lcd_ac_gen u_ac (
    .clk_i, .rst_ni, .wave_b_i,
    .row_end_i(row_end), .frame_end_i(frame_end), .ac_o
  );

  lcd_com_decode #(.NUM_COMS(NUM_COMS)) u_com (
    .clk_i, .rst_ni, .row_i(row), .com_o(com_sel_o)
  );

  assign row_idx_o    = row;
  assign row_strobe_o = row_end;
endmodule

// File: tb/sim_lcd_scan_timer.sv
module sim_lcd_scan_timer;
  localparam int LONG  = 8;
  localparam int SHORT = 4;

  logic clk = 0, rst_n = 0;
  logic two_line = 0, tall = 0, wave_b = 0;
  logic [15:0] com;
  logic [3:0]  row_idx;
  logic        strobe, ac;

  lcd_scan_timer #(.ROW_LONG(LONG), .ROW_SHORT(SHORT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .two_line_i(two_line), .tall_font_i(tall),
    .wave_b_i(wave_b), .com_sel_o(com), .row_idx_o(row_idx),
    .row_strobe_o(strobe), .ac_o(ac)
  );

  always #10 clk = ~clk;

  typedef struct { int row; int com; int m; int len; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, cycles = 0;
  int act = 8;
  bit m_exp = 0;

  task automatic check(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // driver: called in row 0 of a frame; pushes that frame's rows
  task automatic do_frame(input bit two, input bit tl, input bit wb);
    int rows, len;
    wait (q.size() == 0);
    @(negedge clk);
    two_line = two; tall = tl; wave_b = wb;
    rows = act;
    len  = (act == 16) ? SHORT : LONG;
    for (int r = 0; r < rows; r++) begin
      q.push_back('{r, 1 << r, int'(m_exp), len});
      if (!wb || r == rows - 1) m_exp = ~m_exp;
    end
    act = two ? 16 : (tl ? 11 : 8);
  endtask

  // monitor
  initial begin
    int gap = 0;
    bit first = 1;
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        gap++;
        if (strobe) begin
          if (q.size() == 0) begin
            check(0, "R5 unexpected strobe", 1, 0);
          end else begin
            it = q.pop_front();
            check(int'(row_idx) == it.row, "R1 R3 R8 row index", row_idx, it.row);
            check(int'(com) == it.com, "R4 common select", com, it.com);
            check(int'(ac) == it.m, "R6 R7 polarity", ac, it.m);
            if (!first) check(gap == it.len, "R2 R5 row length", gap, it.len);
            first = 0;
          end
          gap = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(row_idx == 0, "R9 reset row", row_idx, 0);
    check(com == 16'h0001, "R9 reset common", com, 1);
    check(ac == 0, "R9 reset polarity", ac, 0);
    check(strobe == 0, "R9 reset strobe", strobe, 0);
    rst_n = 1;
    do_frame(0, 0, 0);  // 8 rows, style A
    do_frame(0, 1, 0);  // still 8 rows: change deferred
    do_frame(0, 1, 1);  // 11 rows, style B
    do_frame(1, 0, 1);  // 11 rows, style B
    do_frame(1, 1, 0);  // 16 rows, style A
    do_frame(0, 0, 1);  // 16 rows (two-line overrides font), style B
    do_frame(0, 0, 0);  // 8 rows, style A
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule